// File: doc/BRIEF.md
# Descriptor DMA Channel Control Registers

This block holds the software-visible registers of one descriptor-driven DMA channel. Its word-wide register port accepts only whole 32-bit accesses. Software starts, pauses, wakes and flushes the channel through a single control address. Each write to that address carries a 16-bit mask in the upper half and a 16-bit value in the lower half. Only the flag bits selected by the mask are changed. From the result the block works out whether the channel is active. When the channel stops, pauses or is asked to flush, the block runs a request/acknowledge flush handshake with the attached device. The new status becomes visible only after that handshake ends.

The descriptor engine is a separate block. It reads the status word, the command pointer and the three condition-select registers from this block's outputs. It reports its own effects through single-cycle event inputs: a fatal error marks the channel dead, a stop descriptor deactivates it, a descriptor fetch clears the wake flag, and branch decisions set or clear the branch-taken flag. The command pointer is locked while the channel is active. When a pointer write is accepted, the pointer is aligned down to a 16-byte boundary and a one-cycle fetch pulse is raised.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset the status word, command pointer and select registers are zero, flush_req is low, and a read of each of the eight register indices returns zero.
- R2: A write to index 0 treats wr_data[31:16] as a mask and wr_data[15:0] as values. The flag positions are run 15, pause 14, flush 13 and wake 12 in both halves. A status flag whose mask bit is 0 keeps its value. A masked run bit written as 1 sets run.
- R3: A masked run bit written as 0 clears run and also clears dead (status bit 11).
- R4: Wake (bit 12) becomes 1 only when it is masked and written as 1 and run is 1 after the same write. Otherwise wake is left unchanged.
- R5: A masked pause bit is copied from the written value, whether that value is 0 or 1.
- R6: After a control write, active (bit 10) is 0 if pause is 1 or run is 0. Otherwise active is set to 1 if run or pause was masked, or if wake was written as 1. Otherwise active keeps its previous value. Active is never 1 while run is 0 or pause is 1.
- R7: A flush written as 1 raises flush_req, and status bit 13 reads 1 until the acknowledge is taken. After that, bit 13 reads 0.
- R8: A control write that leaves pause set or run clear also raises flush_req. During the handshake the status flags keep their old values. The new flags appear on the first clock edge that samples flush_ack high, on the same edge where flush_req falls. flush_req stays high until that edge.
- R9: A write to index 3 is ignored while active is 1. An accepted write stores wr_data with bits 3:0 forced to zero, and fetch_o is high for exactly the next cycle.
- R10: Reads return data one cycle after rd_en. Indices 0 and 1 return the status word. Indices 2 and 7 return zero. Index 3 returns the command pointer. Indices 4, 5 and 6 return the interrupt, branch and wait select registers as last written.
- R11: ev_kill sets dead and clears active. ev_halt clears active. ev_fetch clears wake. ev_bt_set and ev_bt_clr set and clear branch-taken (bit 8). Bits 3:0 of the status word show dev_stat as sampled one cycle earlier.
- R12: While a flush handshake is pending, all register writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word index of the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered |
| dev_stat | input | 4 | Device condition bits |
| ev_kill | input | 1 | Engine event: channel is dead |
| ev_halt | input | 1 | Engine event: stop descriptor reached |
| ev_fetch | input | 1 | Engine event: descriptor fetched |
| ev_bt_set | input | 1 | Engine event: branch taken |
| ev_bt_clr | input | 1 | Engine event: sequential step |
| flush_req | output | 1 | Flush request to the device |
| flush_ack | input | 1 | Flush acknowledge from the device |
| status_o | output | 32 | Current status word |
| cmd_ptr_o | output | 32 | Command pointer |
| fetch_o | output | 1 | Pulse: fetch the descriptor at cmd_ptr_o |
| intr_sel_o | output | 32 | Interrupt condition select |
| br_sel_o | output | 32 | Branch condition select |
| wait_sel_o | output | 32 | Wait condition select |

## Verification
A wrong flag in the status register shows up on status_o in the cycle right after the write or event that caused it. There is one exception: a flag deferred by the flush handshake appears only after the acknowledge edge. A mistaken active flag also shows at the ports, because command-pointer writes are then accepted or refused wrongly, and fetch_o and cmd_ptr_o reveal that one cycle later. A pending copy that is stale or lost is exposed when the acknowledge commits values that differ from those predicted from the write. Writes that leak in during the handshake are exposed by reading the pointer and select registers back after it.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;
  localparam int DEV_W  = 4;

  localparam int B_RUN   = 15;
  localparam int B_PAUSE = 14;
  localparam int B_FLUSH = 13;
  localparam int B_WAKE  = 12;
  localparam int B_DEAD  = 11;
  localparam int B_ACT   = 10;
  localparam int B_BT    = 8;

  typedef struct packed {
    logic run;
    logic pause;
    logic flush;
    logic wake;
    logic dead;
    logic active;
  } chan_flags_t;

  function automatic logic [WORD_W-1:0] pack_status(chan_flags_t f, logic bt,
                                                    logic [DEV_W-1:0] dev);
    logic [WORD_W-1:0] w;
    w = '0;
    w[B_RUN]   = f.run;
    w[B_PAUSE] = f.pause;
    w[B_FLUSH] = f.flush;
    w[B_WAKE]  = f.wake;
    w[B_DEAD]  = f.dead;
    w[B_ACT]   = f.active;
    w[B_BT]    = bt;
    w[DEV_W-1:0] = dev;
    return w;
  endfunction
endpackage

// File: rtl/dcr_ctl_calc.sv
module dcr_ctl_calc
  import dcr_pkg::*;
(
  input  chan_flags_t       cur,
  input  logic [HALF_W-1:0] mask,
  input  logic [HALF_W-1:0] val,
  output chan_flags_t       nxt,
  output logic              need_flush
);
  logic wake_wr;

  always_comb begin
    nxt       = cur;
    nxt.flush = 1'b0;
    wake_wr   = mask[B_WAKE] && val[B_WAKE];
    // run set / clear; clearing also revives a dead channel
    if (mask[B_RUN]) begin
      if (val[B_RUN]) begin
        nxt.run = 1'b1;
      end else begin
        nxt.run  = 1'b0;
        nxt.dead = 1'b0;
      end
    end
    if (wake_wr && nxt.run) nxt.wake = 1'b1;
    if (mask[B_PAUSE]) nxt.pause = val[B_PAUSE];
    need_flush = mask[B_FLUSH] && val[B_FLUSH];
    if (nxt.pause || !nxt.run) begin
      nxt.active = 1'b0;
      need_flush = 1'b1;
    end else if (mask[B_RUN] || mask[B_PAUSE] || wake_wr) begin
      nxt.active = 1'b1;
    end
  end
endmodule

// File: rtl/dcr_flush_hs.sv
module dcr_flush_hs (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic ack,
  output logic req,
  output logic busy,
  output logic done
);
  typedef enum logic {HS_IDLE, HS_WAIT} hs_state_t;
  hs_state_t st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= HS_IDLE;
      req  <= 1'b0;
    end else begin
      case (st_q)
        HS_IDLE: if (start) begin
          st_q <= HS_WAIT;
          req  <= 1'b1;
        end
        HS_WAIT: if (ack) begin
          st_q <= HS_IDLE;
          req  <= 1'b0;
        end
        default: st_q <= HS_IDLE;
      endcase
    end
  end

  assign busy = (st_q == HS_WAIT);
  assign done = busy && ack;

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req && !ack) |=> req);
endmodule

// File: rtl/dcr_sel_bank.sv
module dcr_sel_bank #(
  parameter int N = 3,
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q [N]
);
  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)        q[i] <= '0;
      else if (we[i]) q[i] <= wdata;
    end
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dcr_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int ALIGN_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic [3:0]        dev_stat,
  input  logic              ev_kill,
  input  logic              ev_halt,
  input  logic              ev_fetch,
  input  logic              ev_bt_set,
  input  logic              ev_bt_clr,
  output logic              flush_req,
  input  logic              flush_ack,
  output logic [31:0]       status_o,
  output logic [31:0]       cmd_ptr_o,
  output logic              fetch_o,
  output logic [31:0]       intr_sel_o,
  output logic [31:0]       br_sel_o,
  output logic [31:0]       wait_sel_o
);
  localparam int SEL_N    = 3;
  localparam int SEL_BASE = 4;
  localparam logic [ADDR_W-1:0] IX_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] IX_STAT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] IX_PTR  = ADDR_W'(3);

  chan_flags_t        flags_q, pend_q, nxt;
  logic               bt_q;
  logic [DEV_W-1:0]   dev_q;
  logic [WORD_W-1:0]  ptr_q;
  logic               need_flush, busy, done, start;
  logic               wr_ok, ctl_wr, ptr_wr;
  logic [SEL_N-1:0]   sel_we;
  logic [WORD_W-1:0]  sel_q [SEL_N];
  logic [WORD_W-1:0]  rd_sel;

  assign wr_ok  = wr_en && !busy;
  assign ctl_wr = wr_ok && (addr == IX_CTRL);
  assign ptr_wr = wr_ok && (addr == IX_PTR) && !flags_q.active;
  assign start  = ctl_wr && need_flush;

  dcr_ctl_calc u_calc (
    .cur(flags_q), .mask(wr_data[WORD_W-1:HALF_W]), .val(wr_data[HALF_W-1:0]),
    .nxt(nxt), .need_flush(need_flush)
  );

  dcr_flush_hs u_hs (
    .clk(clk), .rst(rst), .start(start), .ack(flush_ack),
    .req(flush_req), .busy(busy), .done(done)
  );

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < SEL_N; i++) begin
      sel_we[i] = wr_ok && (addr == ADDR_W'(SEL_BASE + i));
      if (addr == ADDR_W'(SEL_BASE + i)) rd_sel = sel_q[i];
    end
  end

  dcr_sel_bank #(.N(SEL_N), .W(WORD_W)) u_sel (
    .clk(clk), .rst(rst), .we(sel_we), .wdata(wr_data), .q(sel_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      pend_q  <= '0;
      bt_q    <= 1'b0;
      dev_q   <= '0;
      ptr_q   <= '0;
      fetch_o <= 1'b0;
      rd_data <= '0;
    end else begin
      dev_q <= dev_stat;
      if (ev_bt_set)      bt_q <= 1'b1;
      else if (ev_bt_clr) bt_q <= 1'b0;

      if (done) begin
        flags_q <= pend_q;
      end else if (start) begin
        flags_q.flush <= wr_data[HALF_W+B_FLUSH] && wr_data[B_FLUSH];
        pend_q        <= nxt;
      end else if (ctl_wr) begin
        flags_q <= nxt;
      end else begin
        if (ev_kill) begin
          flags_q.dead   <= 1'b1;
          flags_q.active <= 1'b0;
        end
        if (ev_halt)  flags_q.active <= 1'b0;
        if (ev_fetch) flags_q.wake   <= 1'b0;
      end

      fetch_o <= ptr_wr;
      if (ptr_wr) ptr_q <= {wr_data[WORD_W-1:ALIGN_W], {ALIGN_W{1'b0}}};

      if (rd_en) begin
        if (addr == IX_CTRL || addr == IX_STAT) rd_data <= status_o;
        else if (addr == IX_PTR)                rd_data <= ptr_q;
        else                                    rd_data <= rd_sel;
      end
    end
  end

  assign status_o   = pack_status(flags_q, bt_q, dev_q);
  assign cmd_ptr_o  = ptr_q;
  assign intr_sel_o = sel_q[0];
  assign br_sel_o   = sel_q[1];
  assign wait_sel_o = sel_q[2];

  // R6
  active_legal_chk: assert property (@(posedge clk) disable iff (rst)
    flags_q.active |-> (flags_q.run && !flags_q.pause));
  // R3
  dead_on_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(flags_q.run) |-> !flags_q.dead);
  // R9
  ptr_lock_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(ptr_q) |-> !$past(flags_q.active));
  // R9
  fetch_src_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_o |-> ($past(wr_en) && !$past(flags_q.active)));
  // R7
  flush_bit_chk: assert property (@(posedge clk) disable iff (rst)
    flags_q.flush |-> flush_req);
endmodule

// File: tb/dma_chan_regs_bench.sv
`timescale 1ns/1ps
module dma_chan_regs_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 0, rd_en = 0;
  logic [2:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [3:0]  dev_stat = '0;
  logic        ev_kill = 0, ev_halt = 0, ev_fetch = 0, ev_bt_set = 0, ev_bt_clr = 0;
  logic        flush_req, flush_ack = 0;
  logic [31:0] status_o, cmd_ptr_o, intr_sel_o, br_sel_o, wait_sel_o;
  logic        fetch_o;

  int checks = 0;
  int errors = 0;

  // expected model: {run,pause,flush,wake,dead,active}
  logic [5:0]  ef = '0;
  logic        ebt = 0;
  logic [3:0]  edev = '0;
  logic [31:0] eptr = '0;
  logic [31:0] esel [3] = '{default: '0};

  always #2.5 clk = ~clk;

  dma_chan_regs u_dma_chan_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .dev_stat(dev_stat),
    .ev_kill(ev_kill), .ev_halt(ev_halt), .ev_fetch(ev_fetch),
    .ev_bt_set(ev_bt_set), .ev_bt_clr(ev_bt_clr),
    .flush_req(flush_req), .flush_ack(flush_ack), .status_o(status_o),
    .cmd_ptr_o(cmd_ptr_o), .fetch_o(fetch_o), .intr_sel_o(intr_sel_o),
    .br_sel_o(br_sel_o), .wait_sel_o(wait_sel_o)
  );

  function automatic logic [31:0] swd(logic [5:0] f, logic bt, logic [3:0] dv);
    logic [31:0] w = '0;
    w[15:10] = f;
    w[8] = bt;
    w[3:0] = dv;
    return w;
  endfunction

  // next flags from the requirement text; bit 6 of result = flush needed
  function automatic logic [6:0] model(logic [5:0] f, logic [15:0] m, logic [15:0] v);
    logic run = f[5], pause = f[4], wake = f[2], dead = f[1], act = f[0];
    logic fl;
    if (m[15]) begin run = v[15]; if (!v[15]) dead = 0; end
    if (m[12] && v[12] && run) wake = 1;
    if (m[14]) pause = v[14];
    fl = m[13] && v[13];
    if (pause || !run) begin act = 0; fl = 1; end
    else if (m[15] || m[14] || (m[12] && v[12])) act = 1;
    return {fl, run, pause, 1'b0, wake, dead, act};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1; addr = a;
    @(posedge clk);
    @(negedge clk);
    rd_en = 0;
    d = rd_data;
  endtask

  task automatic ack_once();
    @(negedge clk);
    flush_ack = 1;
    @(posedge clk);
    @(negedge clk);
    flush_ack = 0;
  endtask

  task automatic ctl(logic [15:0] m, logic [15:0] v, string tag);
    logic [6:0] r = model(ef, m, v);
    logic [5:0] mid = ef;
    wr(3'd0, {m, v});
    if (r[6]) begin
      mid[3] = m[13] && v[13];
      chk({tag, " R8 req"}, {31'b0, flush_req}, 32'd1);
      chk({tag, " R7/R8 mid"}, status_o, swd(mid, ebt, edev));
      repeat ($urandom % 3) @(negedge clk);
      chk({tag, " R8 hold"}, {31'b0, flush_req}, 32'd1);
      ack_once();
    end
    ef = r[5:0];
    chk({tag, " R8 drop"}, {31'b0, flush_req}, 32'd0);
    chk({tag, " R2-flags"}, status_o, swd(ef, ebt, edev));
  endtask

  task automatic ptr_wr(logic [31:0] d);
    logic ok = !ef[0];
    wr(3'd3, d);
    if (ok) eptr = {d[31:4], 4'b0};
    chk("R9 fetch", {31'b0, fetch_o}, {31'b0, ok});
    chk("R9 ptr", cmd_ptr_o, eptr);
    @(negedge clk);
    chk("R9 pulse", {31'b0, fetch_o}, 32'd0);
  endtask

  task automatic ev(int k);
    @(negedge clk);
    case (k)
      0: begin ev_kill = 1; ef[1] = 1; ef[0] = 0; end
      1: begin ev_halt = 1; ef[0] = 0; end
      2: begin ev_fetch = 1; ef[2] = 0; end
      3: begin ev_bt_set = 1; ebt = 1; end
      default: begin ev_bt_clr = 1; ebt = 0; end
    endcase
    @(posedge clk);
    @(negedge clk);
    {ev_kill, ev_halt, ev_fetch, ev_bt_set, ev_bt_clr} = '0;
    chk("R11 event", status_o, swd(ef, ebt, edev));
  endtask

  function automatic logic [31:0] exp_rd(logic [2:0] a);
    case (a)
      3'd0, 3'd1: return swd(ef, ebt, edev);
      3'd3: return eptr;
      3'd4: return esel[0];
      3'd5: return esel[1];
      3'd6: return esel[2];
      default: return 32'd0;
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 status", status_o, 32'd0);
    chk("R1 req", {31'b0, flush_req}, 32'd0);
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), d);
      chk("R1 read", d, 32'd0);
    end
    // R2/R6 start channel
    ctl(16'h8000, 16'h8000, "R2 run");
    chk("R6 active", {31'b0, status_o[10]}, 32'd1);
    // R9 lock
    ptr_wr(32'h0000_1230);
    // R5/R8 pause defers the status until the acknowledge
    ctl(16'h4000, 16'h4000, "R5 pause");
    chk("R6 paused inactive", {31'b0, status_o[10]}, 32'd0);
    ptr_wr(32'h1234_567F);
    ctl(16'h4000, 16'h0000, "R5 unpause");
    // R11 kill then R3 clear run
    ev(0);
    chk("R11 dead", {31'b0, status_o[11]}, 32'd1);
    ctl(16'h8000, 16'h0000, "R3 stop");
    chk("R3 dead clr", {31'b0, status_o[11]}, 32'd0);
    // R4 wake ignored without run
    ctl(16'h1000, 16'h1000, "R4 nowake");
    chk("R4 wake", {31'b0, status_o[12]}, 32'd0);
    ctl(16'h9000, 16'h9000, "R4 wake");
    chk("R4 wake set", {31'b0, status_o[12]}, 32'd1);
    ev(2);
    // R7 flush while running
    ctl(16'h2000, 16'h2000, "R7 flush");
    chk("R7 cleared", {31'b0, status_o[13]}, 32'd0);
    // R12 writes during handshake are dropped
    wr(3'd0, 32'h4000_4000);
    chk("R12 req", {31'b0, flush_req}, 32'd1);
    wr(3'd3, 32'h0000_ABC0);
    wr(3'd4, 32'h5555_5555);
    wr(3'd0, 32'h8000_0000);
    ack_once();
    ef = model(ef, 16'h4000, 16'h4000);
    chk("R12 status", status_o, swd(ef, ebt, edev));
    rd(3'd3, d); chk("R12 ptr", d, eptr);
    rd(3'd4, d); chk("R12 sel", d, 32'd0);
    // R10 select registers and zero indices
    for (int i = 0; i < 3; i++) begin
      esel[i] = $urandom;
      wr(3'(4 + i), esel[i]);
    end
    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    chk("R10 isel", intr_sel_o, esel[0]);
    chk("R10 bsel", br_sel_o, esel[1]);
    chk("R10 wsel", wait_sel_o, esel[2]);
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), d);
      chk("R10 read", d, exp_rd(3'(i)));
    end
    // random mix
    for (int it = 0; it < 400; it++) begin
      int op = $urandom % 8;
      case (op)
        0, 1, 2, 3: ctl(16'($urandom) & 16'hF000, 16'($urandom) & 16'hF000, "R2 rand");
        4: ptr_wr($urandom);
        5: ev($urandom % 5);
        6: begin
          logic [2:0] a = 3'($urandom);
          rd(a, d);
          chk("R10 rand read", d, exp_rd(a));
        end
        default: begin
          @(negedge clk);
          dev_stat = 4'($urandom);
          @(posedge clk);
          @(negedge clk);
          edev = dev_stat;
          chk("R11 dev", status_o, swd(ef, ebt, edev));
        end
      endcase
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule